// File: doc/BRIEF.md
# Multiplier-Free Symmetric FIR Filter (Bit-Serial Distributed Arithmetic)

This block is an eight-tap, linear-phase FIR filter that needs no multiplier. Signed 8-bit samples enter through a valid/ready handshake and move into a tap delay line. The newest sample sits in tap 0. Because the impulse response is symmetric, the filter adds the mirrored taps (0 with 7, 1 with 6, 2 with 5, 3 with 4) before any weighting. Four serial adders produce these pair sums one bit at a time, least significant bit first. Each pair sum is nine bits wide.

On each bit cycle the four current sum bits form a 4-bit index into a sixteen-entry table. Entry k of the table holds the sum of the coefficients whose index bit is set in k. A scaling accumulator folds each table value into a running product and shifts it by one place per cycle, which aligns every value to the weight of its bit. On the final (sign) bit the table value is subtracted instead of added.

After nine bit cycles the block presents two results. The first is the full-precision result, saturated to 16 bits. The second is a rounded 8-bit result, formed by adding half an LSB of the 8-bit result (0x0080 on the 16-bit value) and keeping the upper byte. A single-cycle valid pulse marks each new pair of results. One sample is taken every ten cycles.

Top module: `da_fir_top`

## Requirements
- R1: `in_ready` is high whenever no computation is running. A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. The accepted sample becomes tap 0 and every older tap moves one place down. `in_ready` is low in the cycle after an acceptance.
- R2: With x0 the newest sample and x7 the oldest, `out_full` equals 7*(x0+x7) + 14*(x1+x6) + 18*(x2+x5) + 14*(x3+x4), saturated to the signed 16-bit range. The four coefficients are signed 8-bit values. The serial carries of one sample do not affect the next sample.
- R3: `out_valid` is high for exactly one cycle. It rises after the ninth rising edge that follows the accepting edge. `in_ready` is high again in that same cycle.
- R4: `out_round` equals floor((`out_full` + 128) / 256), clamped to the signed 8-bit range. Both outputs are two's complement.
- R5: A high `in_valid` while `in_ready` is low has no effect. It changes neither the delay line nor any later result.
- R6: `out_full` and `out_round` keep their values between `out_valid` pulses.
- R7: A synchronous reset (`rst` high on a rising edge) clears the delay line, the carries and the accumulator. After reset `in_ready` is 1, `out_valid` is 0 and both results are 0.
- R8: Extreme inputs are weighted exactly. All taps at -128 give pair sums of -256, and all taps at +127 give pair sums of +254. In both cases the result matches R2, including the subtraction on the sign bit.
- R9: An impulse of amplitude A followed by zeros gives the response A times 7, 14, 18, 14, 14, 18, 14, 7 over eight successive samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered on `in_sample` |
| in_sample | input | 8 | Signed input sample |
| in_ready | output | 1 | The filter can take a sample |
| out_valid | output | 1 | One-cycle pulse when both results update |
| out_full | output | 16 | Saturated full-precision result |
| out_round | output | 8 | Rounded 8-bit result |

## Verification
Several properties are checked on every cycle:
- the handshake (`in_ready` drops after an acceptance and is high alongside each result pulse);
- the single-cycle shape of `out_valid`;
- the holding of both results between pulses;
- the bit counter staying within its nine bit cycles;
- subtraction occurring only on the sign bit;
- the serial carries being cleared at the start of each sample.

The arithmetic itself can only be shown by the bench scenarios, which compare both results against a direct multiply-add model. These scenarios cover impulses, steps, extremes of both signs, offers made while the filter is busy, and a long run of random samples.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } phase_e;

  // Clamp a signed value into a w-bit two's complement range.
  function automatic longint clamp_s(input longint v, input int w);
    longint top;
    longint bot;
    top = (longint'(1) <<< (w - 1)) - 1;
    bot = -top - 1;
    if (v > top) return top;
    if (v < bot) return bot;
    return v;
  endfunction

  // Drop 'drop' low bits with round-half-up.
  function automatic longint round_half_up(input longint v, input int drop);
    return (v + (longint'(1) <<< (drop - 1))) >>> drop;
  endfunction

endpackage

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
  parameter int NTAP = 8,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift,
  input  logic [DW-1:0]        din,
  output logic [NTAP*DW-1:0]   taps
);

  logic [DW-1:0] stage_q [NTAP];

  generate
    for (genvar gi = 0; gi < NTAP; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[gi] <= '0;
        end else if (shift) begin
          if (gi == 0) stage_q[gi] <= din;
          else         stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi - 1];
        end
      end
      assign taps[gi*DW +: DW] = stage_q[gi];
    end
  endgenerate

endmodule

// File: rtl/da_fir_sadd.sv
module da_fir_sadd #(
  parameter int DW  = 8,
  parameter int PW  = DW + 1,
  parameter int BIW = $clog2(PW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            en,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [BIW-1:0]  bit_idx,
  output logic            sum_bit,
  output logic            carry_q
);

  // Bit of a sign-extended operand.
  function automatic logic pick(input logic [DW-1:0] x, input logic [BIW-1:0] idx);
    if (int'(idx) >= DW) return x[DW-1];
    return x[idx[$clog2(DW)-1:0]];
  endfunction

  logic a_bit;
  logic b_bit;
  logic carry_d;

  assign a_bit   = pick(a, bit_idx);
  assign b_bit   = pick(b, bit_idx);
  assign sum_bit = a_bit ^ b_bit ^ carry_q;
  assign carry_d = (a_bit & b_bit) | (a_bit & carry_q) | (b_bit & carry_q);

  always_ff @(posedge clk) begin
    if (rst || clr) carry_q <= 1'b0;
    else if (en)    carry_q <= carry_d;
  end

endmodule

// File: rtl/da_fir_dtab.sv
module da_fir_dtab #(
  parameter int NPAIR = 4,
  parameter int CW    = 8,
  parameter int TW    = CW + $clog2(NPAIR),
  parameter logic [NPAIR*CW-1:0] COEFS = {8'h0E, 8'h12, 8'h0E, 8'h07}
) (
  input  logic [NPAIR-1:0]      addr,
  output logic signed [TW-1:0]  tval
);

  localparam int NENT = 2 ** NPAIR;

  function automatic logic signed [TW-1:0] entry_of(input int k);
    logic signed [TW-1:0] acc;
    acc = '0;
    for (int j = 0; j < NPAIR; j++) begin
      if (k[j]) acc = acc + TW'($signed(COEFS[j*CW +: CW]));
    end
    return acc;
  endfunction

  logic signed [TW-1:0] tab [NENT];

  generate
    for (genvar gk = 0; gk < NENT; gk++) begin : g_ent
      assign tab[gk] = entry_of(gk);
    end
  endgenerate

  assign tval = tab[addr];

endmodule

// File: rtl/da_fir_sacc.sv
module da_fir_sacc #(
  parameter int TW = 10,
  parameter int HW = TW + 2,
  parameter int PW = 9,
  parameter int AW = HW + PW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  en,
  input  logic                  sub,
  input  logic signed [TW-1:0]  tval,
  output logic signed [AW-1:0]  prod_nxt
);

  logic signed [AW-1:0] prod_q;
  logic signed [HW-1:0] hi;
  logic signed [HW-1:0] t_ext;
  logic signed [HW-1:0] hi_sum;
  logic signed [AW-1:0] joined;

  assign hi     = prod_q[AW-1:PW];
  assign t_ext  = HW'(tval);
  assign hi_sum = sub ? (hi - t_ext) : (hi + t_ext);
  assign joined = {hi_sum, prod_q[PW-1:0]};
  assign prod_nxt = joined >>> 1;

  always_ff @(posedge clk) begin
    if (rst || clr) prod_q <= '0;
    else if (en)    prod_q <= prod_nxt;
  end

endmodule

// File: rtl/da_fir_top.sv
module da_fir_top
  import da_fir_pkg::*;
#(
  parameter int NTAP = 8,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int OUTW = 16,
  parameter int RNDW = 8,
  parameter logic [(NTAP/2)*CW-1:0] COEFS = {8'h0E, 8'h12, 8'h0E, 8'h07}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_sample,
  output logic             in_ready,
  output logic             out_valid,
  output logic [OUTW-1:0]  out_full,
  output logic [RNDW-1:0]  out_round
);

  localparam int NPAIR = NTAP / 2;
  localparam int PW    = DW + 1;
  localparam int BIW   = $clog2(PW);
  localparam int TW    = CW + $clog2(NPAIR);
  localparam int HW    = TW + 2;
  localparam int AW    = HW + PW;

  phase_e            phase_q;
  logic [BIW-1:0]    bit_idx;
  logic              accept;
  logic              busy;
  logic              last_step;
  logic              sub_step;
  logic [NTAP*DW-1:0] taps;
  logic [NPAIR-1:0]  addr;
  logic [NPAIR-1:0]  carries;
  logic signed [TW-1:0] tval;
  logic signed [AW-1:0] prod_nxt;
  longint            full_l;
  longint            rnd_l;

  assign busy      = (phase_q == PH_BUSY);
  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;
  assign last_step = busy && (bit_idx == BIW'(PW - 1));
  assign sub_step  = last_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      bit_idx <= '0;
    end else if (accept) begin
      phase_q <= PH_BUSY;
      bit_idx <= '0;
    end else if (last_step) begin
      phase_q <= PH_IDLE;
      bit_idx <= '0;
    end else if (busy) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  da_fir_taps #(.NTAP(NTAP), .DW(DW)) u_taps (
    .clk(clk), .rst(rst), .shift(accept), .din(in_sample), .taps(taps)
  );

  generate
    for (genvar gp = 0; gp < NPAIR; gp++) begin : g_pair
      da_fir_sadd #(.DW(DW), .PW(PW), .BIW(BIW)) u_sadd (
        .clk(clk), .rst(rst), .clr(accept), .en(busy),
        .a(taps[gp*DW +: DW]),
        .b(taps[(NTAP-1-gp)*DW +: DW]),
        .bit_idx(bit_idx),
        .sum_bit(addr[gp]),
        .carry_q(carries[gp])
      );
    end
  endgenerate

  da_fir_dtab #(.NPAIR(NPAIR), .CW(CW), .TW(TW), .COEFS(COEFS)) u_tab (
    .addr(addr), .tval(tval)
  );

  da_fir_sacc #(.TW(TW), .HW(HW), .PW(PW), .AW(AW)) u_acc (
    .clk(clk), .rst(rst), .clr(accept), .en(busy), .sub(sub_step),
    .tval(tval), .prod_nxt(prod_nxt)
  );

  assign full_l = clamp_s(longint'(prod_nxt), OUTW);
  assign rnd_l  = clamp_s(round_half_up(full_l, OUTW - RNDW), RNDW);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_full  <= '0;
      out_round <= '0;
    end else begin
      out_valid <= last_step;
      if (last_step) begin
        out_full  <= full_l[OUTW-1:0];
        out_round <= rnd_l[RNDW-1:0];
      end
    end
  end

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int OUTW  = 16,
  parameter int RNDW  = 8,
  parameter int PW    = 9,
  parameter int NPAIR = 4,
  parameter int BIW   = $clog2(PW)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUTW-1:0]  out_full,
  input logic [RNDW-1:0]  out_round,
  input logic             busy,
  input logic [BIW-1:0]   bit_idx,
  input logic             sub_step,
  input logic [NPAIR-1:0] carries
);

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);  // R1

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);  // R3

  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);  // R3

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(bit_idx) < PW));  // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> (out_valid || ($stable(out_full) && $stable(out_round))));  // R6

  AST_SIGN_SUBTRACT: assert property (@(posedge clk) disable iff (rst)
    sub_step |-> (busy && int'(bit_idx) == PW - 1));  // R8

  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (carries == '0));  // R2

endmodule

bind da_fir_top da_fir_chk #(
  .OUTW(OUTW), .RNDW(RNDW), .PW(PW), .NPAIR(NPAIR), .BIW(BIW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_full(out_full), .out_round(out_round),
  .busy(busy), .bit_idx(bit_idx), .sub_step(sub_step), .carries(carries)
);

// File: tb/da_fir_top_test.sv
module da_fir_top_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] in_sample;
  logic       in_ready;
  logic       out_valid;
  logic [15:0] out_full;
  logic [7:0]  out_round;

  int total = 0;
  int fails = 0;
  int hist [8];
  int last_full = 0;

  always #10 clk = ~clk;

  da_fir_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .out_valid(out_valid),
    .out_full(out_full), .out_round(out_round)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_full();
    int c [4] = '{7, 14, 18, 14};
    int s = 0;
    for (int j = 0; j < 4; j++) s += c[j] * (hist[j] + hist[7-j]);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic int model_round(input int f);
    int t = f + 128;
    int m = ((t % 256) + 256) % 256;
    int r = (t - m) / 256;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  // Offer one sample; optionally poke in_valid while busy (R5).
  task automatic send(input int s, input bit poke, input bit verbose);
    int cnt;
    int ef;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 8'(s);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
    if (verbose) check(in_ready == 1'b0, "R1 ready low after accept", int'(in_ready), 0);
    cnt = 0;
    while (!out_valid && cnt < 40) begin
      if (poke && cnt >= 1 && cnt <= 3) begin
        in_valid  = 1'b1;
        in_sample = 8'd100;
      end else begin
        in_valid = 1'b0;
      end
      if (verbose && cnt == 4)
        check($signed(out_full) == last_full, "R6 result held", int'($signed(out_full)), last_full);
      @(negedge clk);
      cnt++;
    end
    in_valid = 1'b0;
    ef = model_full();
    if (verbose) begin
      check(cnt == 9, "R3 latency", cnt, 9);
      check(in_ready == 1'b1, "R3 ready with result", int'(in_ready), 1);
    end
    check($signed(out_full) == ef, "R2 full result", int'($signed(out_full)), ef);
    check($signed(out_round) == model_round(ef), "R4 rounded result",
          int'($signed(out_round)), model_round(ef));
    last_full = ef;
    @(negedge clk);
    if (verbose) check(out_valid == 1'b0, "R3 single pulse", int'(out_valid), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    in_sample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) hist[k] = 0;
    last_full = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    int imp [8] = '{7, 14, 18, 14, 14, 18, 14, 7};
    seed = 1234;
    void'($urandom(seed));

    // R7: reset state
    do_reset();
    check(in_ready == 1'b1, "R7 reset ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
    check(out_full == '0, "R7 reset full", int'(out_full), 0);
    check(out_round == '0, "R7 reset round", int'(out_round), 0);

    // R9: impulse response, amplitude 64
    send(64, 1'b0, 1'b1);
    check($signed(out_full) == 64 * imp[0], "R9 impulse tap", int'($signed(out_full)), 64 * imp[0]);
    for (int k = 1; k < 8; k++) begin
      send(0, 1'b0, 1'b1);
      check($signed(out_full) == 64 * imp[k], "R9 impulse tap", int'($signed(out_full)), 64 * imp[k]);
    end
    send(0, 1'b0, 1'b1);

    // R8: extremes, and step response
    for (int k = 0; k < 8; k++) send(127, 1'b0, 1'b0);
    check($signed(out_full) == 13462, "R8 positive extreme", int'($signed(out_full)), 13462);
    for (int k = 0; k < 8; k++) send(-128, 1'b0, 1'b0);
    check($signed(out_full) == -13568, "R8 negative extreme", int'($signed(out_full)), -13568);
    check($signed(out_round) == -53, "R8 negative extreme rounded", int'($signed(out_round)), -53);
    send(127, 1'b0, 1'b1);

    // R5: offers while busy are ignored
    for (int k = 0; k < 6; k++) send(int'($urandom_range(255)) - 128, 1'b1, 1'b1);

    // R7: reset mid-stream clears the delay line
    do_reset();
    send(-3, 1'b0, 1'b1);
    check($signed(out_full) == -21, "R7 cleared delay line", int'($signed(out_full)), -21);

    // Random stream (R2, R4)
    for (int k = 0; k < 150; k++) send(int'($urandom_range(255)) - 128, 1'b0, (k % 10) == 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule